// File: doc/BRIEF.md
# Circular Command Queue Consumer

This block drains fixed-size command entries from a ring buffer held in system memory. Software places entries in the ring and moves a producer index forward. The block owns the consumer index. Both indices are `QLOG2+1` bits wide. The low `QLOG2` bits select a slot, and the top bit is a wrap flag that flips each time the slot number rolls from the last slot back to zero. While the queue is enabled and the two indices differ, the block fetches the entry under the consumer index through a read request/response port and decodes its opcode. It then either retires the entry as a no-op, retires it as a sync that may signal an interrupt, or halts with an error.

Errors are reported through a toggle-style global error bit. The block flips `gerr` to raise an error. Software acknowledges by copying that value onto `gerr_ack`. An error is pending while the two differ, and nothing is fetched during that time. The cause is kept in a small error-code field next to the consumer index. A failing entry is never retired, so once software repairs it and acknowledges, the same slot is fetched again.

The read request side is valid/ready. The block raises `rd_req_valid` with a stable address and holds both until `rd_req_ready` is seen high at a clock edge. Only one read is ever outstanding. A response is taken only in a cycle where `rd_rsp_ready` is high, and the block never stalls a response once its request has been accepted.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset, `cons_idx` is 0, `cons_err` is 0, `gerr` is 0, and `rd_req_valid`, `sync_irq` and `gerr_irq` are low.
- R2: No read request is issued while `cmdq_en` is low, and the consumer index does not move while it is low.
- R3: The queue is empty when `prod_idx` equals `cons_idx` in all bits, including the wrap bit. Processing continues until that holds. The consumer index only ever steps by one modulo 2^(QLOG2+1), so a producer that is a full ring ahead (low bits equal, wrap bit different) drains all 2^QLOG2 entries.
- R4: No new entry is fetched while an error is pending (`gerr` differs from `gerr_ack`). Processing resumes after software makes them equal.
- R5: The request address is `q_base + (cons_idx[QLOG2-1:0] << ENTRY_LOG2)`. While `rd_req_valid` is high and `rd_req_ready` is low, the request and its address stay unchanged.
- R6: The opcode is bits 7:0 of the first response word. Opcodes 0x01–0x06, 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A, 0x30, 0x40, 0x41, 0x44, 0x45 and 0x46 (sync) retire, and each retirement advances `cons_idx` by one.
- R7: Any other opcode leaves `cons_idx` on the offending entry and writes code 1 into `cons_err`.
- R8: A response with `rd_rsp_err` set leaves `cons_idx` unchanged and writes code 2 into `cons_err`.
- R9: A sync entry (opcode 0x46) whose bits 13:12 equal 1 gives a one-cycle `sync_irq` pulse in the same cycle that `cons_idx` advances past it. Values 0, 2 and 3 give no pulse.
- R10: On an error, `gerr` flips only if no error is pending, and every flip comes with a one-cycle `gerr_irq` pulse.
- R11: `cons_err` keeps the last error code, including after later entries retire successfully.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdq_en | input | 1 | Queue processing enable |
| q_base | input | ADDR_W | Byte address of ring slot 0 |
| prod_idx | input | QLOG2+1 | Producer index with wrap bit |
| cons_idx | output | QLOG2+1 | Consumer index with wrap bit |
| cons_err | output | ERR_W | Last error code (0 none, 1 illegal, 2 abort) |
| gerr_ack | input | 1 | Software acknowledge copy of the error bit |
| gerr | output | 1 | Toggle-style command error bit |
| gerr_irq | output | 1 | Pulse on each flip of `gerr` |
| sync_irq | output | 1 | Sync-completion interrupt pulse |
| rd_req_valid | output | 1 | Entry read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Entry byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Block accepts a response |
| rd_rsp_data | input | DATA_W | First word of the entry |
| rd_rsp_err | input | 1 | Read response carries an error |

## Verification
Two things can land on the same clock edge here: retiring a sync entry, which moves the consumer index, and raising the sync interrupt. The bench runs sync entries with each of the four completion-signal values between other commands. A monitor samples both outputs at every falling edge and flags any pulse that does not appear together with a one-step change of the index. The bench also counts the pulses and compares the total with the number of entries whose field was 1.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} cq_state_e;
  typedef enum logic [1:0] {CK_NOP, CK_SYNC, CK_ILLEGAL} cmd_kind_e;

  localparam logic [6:0] CQ_ERR_NONE = 7'd0;
  localparam logic [6:0] CQ_ERR_ILL  = 7'd1;
  localparam logic [6:0] CQ_ERR_ABT  = 7'd2;

  localparam logic [7:0] OP_SYNC     = 8'h46;
  localparam logic [1:0] CS_SIG_IRQ  = 2'd1;
endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
  import cmdq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  output cmd_kind_e         kind,
  output logic              irq_req
);
  logic [7:0] op;
  assign op = word[7:0];

  always_comb begin
    unique case (op)
      8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
      8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
      8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A,
      8'h30, 8'h40, 8'h41, 8'h44, 8'h45: kind = CK_NOP;
      OP_SYNC:                            kind = CK_SYNC;
      default:                            kind = CK_ILLEGAL;
    endcase
  end

  // completion-signal field of a sync entry lives in bits 13:12
  assign irq_req = (kind == CK_SYNC) && (word[13:12] == CS_SIG_IRQ);
endmodule

// File: rtl/cmdq_index.sv
module cmdq_index #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] prod,
  output logic [IDX_W-1:0] cons,
  output logic             empty
);
  // natural overflow of the full index flips the wrap bit on rollover
  always_ff @(posedge clk) begin
    if (!rst_n)    cons <= '0;
    else if (step) cons <= cons + 1'b1;
  end

  assign empty = (cons == prod);
endmodule

// File: rtl/cmdq_gerr.sv
module cmdq_gerr (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic ack,
  output logic flag,
  output logic pending,
  output logic irq
);
  assign pending = flag ^ ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (raise && !pending) begin
        flag <= ~flag;
        irq  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
  import cmdq_pkg::*;
#(
  parameter int  ADDR_W     = 32,
  parameter int  DATA_W     = 32,
  parameter int  QLOG2      = 3,
  parameter int  ENTRY_LOG2 = 4,
  parameter int  ERR_W      = 7,
  localparam int IDX_W      = QLOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdq_en,
  input  logic [ADDR_W-1:0] q_base,
  input  logic [IDX_W-1:0]  prod_idx,
  output logic [IDX_W-1:0]  cons_idx,
  output logic [ERR_W-1:0]  cons_err,
  input  logic              gerr_ack,
  output logic              gerr,
  output logic              gerr_irq,
  output logic              sync_irq,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err
);
  cq_state_e  state;
  cmd_kind_e  kind;
  logic       irq_req, empty, pending;
  logic       rsp_fire, cmd_ok, raise;
  logic [ADDR_W-1:0] slot_off;

  cmdq_decode #(.DATA_W(DATA_W)) u_dec (
    .word(rd_rsp_data), .kind(kind), .irq_req(irq_req)
  );

  cmdq_index #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .step(cmd_ok),
    .prod(prod_idx), .cons(cons_idx), .empty(empty)
  );

  cmdq_gerr u_gerr (
    .clk(clk), .rst_n(rst_n), .raise(raise), .ack(gerr_ack),
    .flag(gerr), .pending(pending), .irq(gerr_irq)
  );

  assign rsp_fire = (state == ST_WAIT) && rd_rsp_valid;
  assign cmd_ok   = rsp_fire && !rd_rsp_err && (kind != CK_ILLEGAL);
  assign raise    = rsp_fire && !cmd_ok;

  assign slot_off     = ADDR_W'(cons_idx[QLOG2-1:0]) << ENTRY_LOG2;
  assign rd_req_addr  = q_base + slot_off;
  assign rd_req_valid = (state == ST_REQ);
  assign rd_rsp_ready = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cons_err <= '0;
      sync_irq <= 1'b0;
    end else begin
      sync_irq <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmdq_en && !empty && !pending) state <= ST_REQ;
        ST_REQ:  if (rd_req_ready) state <= ST_WAIT;
        ST_WAIT: if (rd_rsp_valid) begin
          state <= ST_IDLE;
          if (rd_rsp_err)              cons_err <= ERR_W'(CQ_ERR_ABT);
          else if (kind == CK_ILLEGAL) cons_err <= ERR_W'(CQ_ERR_ILL);
          else if (irq_req)            sync_irq <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_consumer_chk.sv
module cmdq_consumer_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmdq_en,
  input logic [IDX_W-1:0]  prod_idx,
  input logic [IDX_W-1:0]  cons_idx,
  input logic              gerr_ack,
  input logic              gerr,
  input logic              gerr_irq,
  input logic              sync_irq,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr
);
  assert_req_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> $past(cmdq_en));

  assert_req_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> ($past(prod_idx) != $past(cons_idx)));

  assert_cons_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_idx != $past(cons_idx)) |-> (cons_idx == IDX_W'($past(cons_idx) + 1'b1)));

  assert_req_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> ($past(gerr) == $past(gerr_ack)));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  assert_sync_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_irq |-> (cons_idx == IDX_W'($past(cons_idx) + 1'b1)));

  assert_gerr_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gerr != $past(gerr)) |-> (($past(gerr) == $past(gerr_ack)) && gerr_irq));
endmodule

bind cmdq_consumer cmdq_consumer_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmdq_en(cmdq_en), .prod_idx(prod_idx),
  .cons_idx(cons_idx), .gerr_ack(gerr_ack), .gerr(gerr), .gerr_irq(gerr_irq),
  .sync_irq(sync_irq), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr)
);

// File: tb/tb_cmdq_consumer.sv
module tb_cmdq_consumer;
  localparam int ADDR_W = 32, DATA_W = 32, QLOG2 = 3, ELOG = 4, ERR_W = 7;
  localparam int IDX_W = QLOG2 + 1;
  localparam int NSLOT = 1 << QLOG2;
  localparam logic [ADDR_W-1:0] BASE = 32'h8000_1000;

  logic clk = 1'b0, rst_n = 1'b0, cmdq_en = 1'b0;
  logic [ADDR_W-1:0] q_base = BASE;
  logic [IDX_W-1:0]  prod_idx = '0;
  logic [IDX_W-1:0]  cons_idx;
  logic [ERR_W-1:0]  cons_err;
  logic gerr_ack = 1'b0, gerr, gerr_irq, sync_irq;
  logic rd_req_valid, rd_req_ready = 1'b1, rd_rsp_valid = 1'b0, rd_rsp_ready, rd_rsp_err = 1'b0;
  logic [ADDR_W-1:0] rd_req_addr;
  logic [DATA_W-1:0] rd_rsp_data = '0;

  logic [7:0] m_op  [NSLOT];
  logic [1:0] m_cs  [NSLOT];
  logic       m_bad [NSLOT];

  int n_chk = 0, n_err = 0;
  int sync_cnt = 0, gerr_irq_cnt = 0, req_cnt = 0, sync_misalign = 0;
  logic [IDX_W-1:0] exp_cons;
  logic exp_gerr;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmdq_consumer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .QLOG2(QLOG2),
                  .ENTRY_LOG2(ELOG), .ERR_W(ERR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmdq_en(cmdq_en), .q_base(q_base),
    .prod_idx(prod_idx), .cons_idx(cons_idx), .cons_err(cons_err),
    .gerr_ack(gerr_ack), .gerr(gerr), .gerr_irq(gerr_irq), .sync_irq(sync_irq),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic bit legal_op(input logic [7:0] op);
    case (op)
      8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h10, 8'h11, 8'h12, 8'h13,
      8'h18, 8'h1A, 8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A, 8'h30,
      8'h40, 8'h41, 8'h44, 8'h45, 8'h46: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // memory responder: one response, one cycle after each accepted request
  initial begin
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      if (rst_n && rd_req_valid && rd_req_ready) begin
        automatic int slot = int'(cons_idx[QLOG2-1:0]);
        chk("R5 address", int'(rd_req_addr), int'(BASE + (slot << ELOG)));
        @(negedge clk);
        rd_rsp_valid = 1'b1;
        rd_rsp_err   = m_bad[slot];
        rd_rsp_data  = {18'h0, m_cs[slot], 4'h0, m_op[slot]};
      end
    end
  end

  // pulse monitor
  initial begin
    logic [IDX_W-1:0] prev = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (sync_irq) begin
          sync_cnt++;
          if (cons_idx != IDX_W'(prev + 1'b1)) sync_misalign++;
        end
        if (gerr_irq) gerr_irq_cnt++;
        if (rd_req_valid && rd_req_ready) req_cnt++;
      end
      prev = cons_idx;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    for (int i = 0; i < NSLOT; i++) begin m_op[i] = 8'h01; m_cs[i] = 2'd0; m_bad[i] = 1'b0; end
    settle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cons_idx", int'(cons_idx), 0);
    chk("R1 cons_err", int'(cons_err), 0);
    chk("R1 gerr", int'(gerr), 0);
    chk("R1 req_valid", int'(rd_req_valid), 0);
    chk("R1 pulses", int'(sync_irq) + int'(gerr_irq), 0);
    exp_cons = '0; exp_gerr = 1'b0;

    // R2 enable gating
    prod_idx = 4'd3;
    settle(20);
    chk("R2 cons held while disabled", int'(cons_idx), 0);
    chk("R2 no request while disabled", req_cnt, 0);
    cmdq_en = 1'b1;
    settle(20);
    exp_cons = 4'd3;
    chk("R6 three no-ops retire", int'(cons_idx), int'(exp_cons));

    // R6/R7/R10/R3 opcode sweep, index wraps many times
    for (int op = 0; op < 256; op++) begin
      automatic int slot = int'(exp_cons[QLOG2-1:0]);
      automatic int g0 = gerr_irq_cnt;
      m_op[slot] = 8'(op); m_cs[slot] = 2'd0;
      prod_idx = IDX_W'(exp_cons + 1'b1);
      settle(8);
      if (legal_op(8'(op))) begin
        exp_cons = IDX_W'(exp_cons + 1'b1);
        chk("R6 legal opcode retires", int'(cons_idx), int'(exp_cons));
      end else begin
        exp_gerr = ~exp_gerr;
        chk("R7 illegal holds index", int'(cons_idx), int'(exp_cons));
        chk("R7 illegal code", int'(cons_err), 1);
        chk("R10 gerr flipped", int'(gerr), int'(exp_gerr));
        chk("R10 gerr_irq pulse", gerr_irq_cnt - g0, 1);
        m_op[slot] = 8'h01;
        gerr_ack = gerr;
        settle(8);
        exp_cons = IDX_W'(exp_cons + 1'b1);
        chk("R4 resumes after ack", int'(cons_idx), int'(exp_cons));
      end
    end

    // R4 pending halts, including a pending made by software
    begin
      automatic int r0 = req_cnt;
      gerr_ack = ~gerr;
      prod_idx = IDX_W'(exp_cons + 2'd2);
      settle(20);
      chk("R4 no fetch while pending", req_cnt - r0, 0);
      chk("R4 index held while pending", int'(cons_idx), int'(exp_cons));
      gerr_ack = gerr;
      settle(12);
      exp_cons = IDX_W'(exp_cons + 2'd2);
      chk("R4 drains after ack", int'(cons_idx), int'(exp_cons));
    end

    // R8 abort, repeated abort, R11 code retention
    begin
      automatic int slot = int'(exp_cons[QLOG2-1:0]);
      m_bad[slot] = 1'b1;
      prod_idx = IDX_W'(exp_cons + 1'b1);
      settle(8);
      exp_gerr = ~exp_gerr;
      chk("R8 abort code", int'(cons_err), 2);
      chk("R8 abort holds index", int'(cons_idx), int'(exp_cons));
      chk("R10 gerr after abort", int'(gerr), int'(exp_gerr));
      gerr_ack = gerr;
      settle(8);
      exp_gerr = ~exp_gerr;
      chk("R10 second abort flips again", int'(gerr), int'(exp_gerr));
      chk("R8 still held", int'(cons_idx), int'(exp_cons));
      m_bad[slot] = 1'b0;
      gerr_ack = gerr;
      settle(8);
      exp_cons = IDX_W'(exp_cons + 1'b1);
      chk("R8 retires once readable", int'(cons_idx), int'(exp_cons));
      chk("R11 code kept after success", int'(cons_err), 2);
    end

    // R9 sync completion-signal field sweep
    for (int cs = 0; cs < 4; cs++) begin
      automatic int slot = int'(exp_cons[QLOG2-1:0]);
      automatic int s0 = sync_cnt;
      m_op[slot] = 8'h46; m_cs[slot] = 2'(cs);
      prod_idx = IDX_W'(exp_cons + 1'b1);
      settle(8);
      exp_cons = IDX_W'(exp_cons + 1'b1);
      chk("R9 sync retires", int'(cons_idx), int'(exp_cons));
      chk("R9 sync pulse count", sync_cnt - s0, (cs == 1) ? 1 : 0);
      m_cs[slot] = 2'd0; m_op[slot] = 8'h01;
    end
    chk("R9 pulse aligned with advance", sync_misalign, 0);

    // R3 full ring: low bits equal, wrap bit different
    for (int i = 0; i < NSLOT; i++) begin m_op[i] = 8'h46; m_cs[i] = 2'd1; end
    begin
      automatic int s0 = sync_cnt;
      prod_idx = exp_cons ^ IDX_W'(NSLOT);
      settle(40);
      exp_cons = prod_idx;
      chk("R3 full ring drains", int'(cons_idx), int'(exp_cons));
      chk("R9 one pulse per sync", sync_cnt - s0, NSLOT);
      chk("R3 stops when equal incl wrap", int'(rd_req_valid), 0);
    end
    chk("R9 pulse aligned with advance", sync_misalign, 0);

    done = 1'b1;
    report();
  end
endmodule